// File: doc/BRIEF.md
# RTC update-cycle sequencer

This block paces the once-per-second rewrite of a real-time clock's time and calendar registers. A one-second strobe from the divider chain opens a cycle. The busy status goes high at once. It stays high for a lead interval of slow-clock ticks, during which the counters still hold their old values. A write window follows, and only inside it may the counter logic change the time bytes. A short tail then passes before busy drops.

At the end of the tail the block raises a sticky done flag. The flag stays set until software reads the flag register. The block's interrupt contribution is the done flag, gated by an enable bit and blocked by an inhibit bit.

Software that sees busy low knows at least the lead interval remains before any byte changes. Software that takes the done interrupt has almost a full second before the next cycle. While the divider is held in reset, no cycle runs.

Top module: `rtc_upd_seq`

## Requirements
- R1: After reset, `upd_busy`, `upd_done`, `cnt_wr_en` and `irq_upd` are all 0.
- R2: A `sec_tick` pulse seen while idle and with `div_hold` low sets `upd_busy` to 1 on the next clock.
- R3: `cnt_wr_en` stays 0 until LEAD_TICKS `tick32` pulses have been taken after `upd_busy` rose. It goes to 1 on the clock edge that takes the last of them.
- R4: `cnt_wr_en` stays 1 for exactly WIN_TICKS `tick32` pulses.
- R5: `upd_busy` is 1 whenever `cnt_wr_en` is 1. It falls TAIL_TICKS `tick32` pulses after the window closes.
- R6: `upd_done` becomes 1 only on the edge where `upd_busy` falls at the end of a complete cycle. Without a read, it then stays 1.
- R7: A `flag_rd` pulse clears `upd_done` on the next edge. When the read coincides with the end of a cycle, the set wins.
- R8: `irq_upd` is 1 exactly when `upd_done` is 1, `upd_irq_en` is 1 and `upd_irq_inh` is 0.
- R9: While `div_hold` is 1, no cycle starts and `upd_busy` and `cnt_wr_en` read 0. Raising it mid-cycle abandons the cycle without setting `upd_done`.
- R10: A `sec_tick` pulse that arrives while a cycle is running is ignored. It neither restarts nor extends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32 | input | 1 | One-clock enable at the 32.768 kHz rate |
| sec_tick | input | 1 | One-clock strobe once per second |
| div_hold | input | 1 | Divider held in reset; blocks and aborts cycles |
| flag_rd | input | 1 | Flag register read strobe; clears the done flag |
| upd_irq_en | input | 1 | Update-ended interrupt enable |
| upd_irq_inh | input | 1 | Update-ended interrupt inhibit |
| upd_busy | output | 1 | Update in progress status |
| upd_done | output | 1 | Sticky update-ended flag |
| cnt_wr_en | output | 1 | Window in which the time counters may change |
| irq_upd | output | 1 | Update-ended interrupt contribution |

## Verification
The bench builds the block with LEAD_TICKS=3, WIN_TICKS=2 and TAIL_TICKS=1, and feeds a slow tick every fourth clock. With these values a whole cycle takes about 25 clocks. That makes it cheap to run many cycles, each followed by an exact tick count for every edge of busy and window. The short cycle also lets the bench place a read on the final edge and drop a second strobe into the lead phase. It can also abort a cycle with the divider hold, which at realistic lead lengths would cost thousands of clocks.

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int LEAD_TICKS = 8,
  parameter int WIN_TICKS  = 2,
  parameter int TAIL_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick32,
  input  logic sec_tick,
  input  logic div_hold,
  input  logic flag_rd,
  input  logic upd_irq_en,
  input  logic upd_irq_inh,
  output logic upd_busy,
  output logic upd_done,
  output logic cnt_wr_en,
  output logic irq_upd
);
  localparam int MAXT = (LEAD_TICKS > WIN_TICKS)
                        ? ((LEAD_TICKS > TAIL_TICKS) ? LEAD_TICKS : TAIL_TICKS)
                        : ((WIN_TICKS > TAIL_TICKS) ? WIN_TICKS : TAIL_TICKS);
  localparam int CW = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_TICKS - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_WIN, S_TAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          last;
  logic          fin;

  always_comb begin
    case (st)
      S_LEAD:  lim = LEAD_LAST;
      S_WIN:   lim = WIN_LAST;
      default: lim = TAIL_LAST;
    endcase
  end

  assign last = tick32 && (cnt == lim);
  assign fin  = !div_hold && (st == S_TAIL) && last;

  always_ff @(posedge clk) begin
    if (!rst_n || div_hold) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (st == S_IDLE) begin
      cnt <= '0;
      if (sec_tick) st <= S_LEAD;
    end else if (last) begin
      cnt <= '0;
      case (st)
        S_LEAD:  st <= S_WIN;
        S_WIN:   st <= S_TAIL;
        default: st <= S_IDLE;
      endcase
    end else if (tick32) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       upd_done <= 1'b0;
    else if (fin)     upd_done <= 1'b1;
    else if (flag_rd) upd_done <= 1'b0;
  end

  assign upd_busy  = (st != S_IDLE);
  assign cnt_wr_en = (st == S_WIN);
  assign irq_upd   = upd_done && upd_irq_en && !upd_irq_inh;
endmodule

// File: rtl/rtc_upd_seq_chk.sv
module rtc_upd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick32,
  input logic sec_tick,
  input logic div_hold,
  input logic flag_rd,
  input logic upd_irq_en,
  input logic upd_irq_inh,
  input logic upd_busy,
  input logic upd_done,
  input logic cnt_wr_en,
  input logic irq_upd
);
  a_r2_strobe_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !div_hold && !upd_busy) |=> upd_busy);

  a_r5_window_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |-> upd_busy);

  a_r3_lead_before_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_wr_en) |-> $past(upd_busy));

  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_done) |-> $fell(upd_busy));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !flag_rd) |=> upd_done);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |=> (!upd_done || $fell(upd_busy)));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_irq_inh || !upd_irq_en || !upd_done) |-> !irq_upd);

  a_r9_hold_idles: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> (!upd_busy && !cnt_wr_en));
endmodule

bind rtc_upd_seq rtc_upd_seq_chk u_chk (.*);

// File: tb/sim_rtc_upd_seq.sv
module sim_rtc_upd_seq;
  localparam int LT = 3, WT = 2, TT = 1;
  localparam int E_RISE = 0, E_WON = 1, E_WOFF = 2, E_FALL = 3;

  typedef struct {int code; int tc; bit done;} ev_t;

  logic clk = 0, rst_n = 0, tick32 = 0, sec_tick = 0, div_hold = 0, flag_rd = 0;
  logic upd_irq_en = 0, upd_irq_inh = 0;
  logic upd_busy, upd_done, cnt_wr_en, irq_upd;
  int checks = 0, errors = 0, cyc = 0;
  bit  tick_on = 0;
  logic [1:0] div = 0;
  ev_t q[$];

  always #2.5 clk = ~clk;

  rtc_upd_seq #(.LEAD_TICKS(LT), .WIN_TICKS(WT), .TAIL_TICKS(TT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick32(tick32), .sec_tick(sec_tick),
    .div_hold(div_hold), .flag_rd(flag_rd), .upd_irq_en(upd_irq_en),
    .upd_irq_inh(upd_irq_inh), .upd_busy(upd_busy), .upd_done(upd_done),
    .cnt_wr_en(cnt_wr_en), .irq_upd(irq_upd));

  always @(negedge clk) begin
    div    <= div + 1'b1;
    tick32 <= tick_on && (div == 2'd3);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: counts ticks taken since busy rose and compares edges with the queue
  logic pb = 0, pw = 0;
  int tc = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (pb && tick32) tc++;
      if (upd_busy && !pb) begin tc = 0; pop(E_RISE); end
      if (cnt_wr_en && !pw) pop(E_WON);
      if (!cnt_wr_en && pw) pop(E_WOFF);
      if (!upd_busy && pb) pop(E_FALL);
    end
    pb = upd_busy;
    pw = cnt_wr_en;
  end

  task automatic pop(input int code);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R10: actual unexpected event %0d expected none", code);
      return;
    end
    e = q.pop_front();
    if (e.code != code) begin
      errors++;
      $display("FAIL R2-5 order: actual event %0d expected %0d", code, e.code);
    end else if (e.tc >= 0 && e.tc != tc) begin
      errors++;
      $display("FAIL R3/R4/R5 timing: event %0d actual tick %0d expected %0d", code, tc, e.tc);
    end else if (code == E_FALL && upd_done != e.done) begin
      errors++;
      $display("FAIL R6: done at busy fall actual %0d expected %0d", upd_done, e.done);
    end
  endtask

  task automatic push(input int code, input int t, input bit d);
    ev_t e;
    e.code = code; e.tc = t; e.done = d;
    q.push_back(e);
  endtask

  task automatic push_cycle();
    push(E_RISE, 0, 0);
    push(E_WON, LT, 0);
    push(E_WOFF, LT + WT, 0);
    push(E_FALL, LT + WT + TT, 1);
  endtask

  task automatic pulse_sec();
    @(negedge clk) sec_tick = 1;
    @(negedge clk) sec_tick = 0;
  endtask

  task automatic wait_idle();
    while (upd_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycle();
    push_cycle();
    pulse_sec();
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", upd_busy, 0);
    chk("R1 done", upd_done, 0);
    chk("R1 window", cnt_wr_en, 0);
    chk("R1 irq", irq_upd, 0);
    rst_n = 1; tick_on = 1;
    upd_irq_en = 1;
    repeat (4) @(negedge clk);

    // R2..R6 normal cycle
    run_cycle();
    chk("R6 done held", upd_done, 1);
    chk("R8 irq enabled", irq_upd, 1);
    upd_irq_inh = 1; @(negedge clk);
    chk("R8 irq inhibited", irq_upd, 0);
    upd_irq_inh = 0; upd_irq_en = 0; @(negedge clk);
    chk("R8 irq disabled", irq_upd, 0);
    upd_irq_en = 1; @(negedge clk);
    chk("R8 irq back", irq_upd, 1);

    // R7 read clears
    flag_rd = 1; @(negedge clk); flag_rd = 0;
    chk("R7 done cleared", upd_done, 0);
    chk("R8 irq after clear", irq_upd, 0);

    // R10 second strobe during lead
    push_cycle();
    pulse_sec();
    repeat (3) @(negedge clk);
    pulse_sec();
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R10 no restart busy", upd_busy, 0);
    chk("R10 queue drained", q.size(), 0);

    // R7 collision: read held across the end edge
    flag_rd = 1;
    push_cycle();
    pulse_sec();
    wait_idle();
    chk("R7 read after set clears", upd_done, 0);
    flag_rd = 0;

    // R9 hold blocks start
    div_hold = 1;
    pulse_sec();
    repeat (10) @(negedge clk);
    chk("R9 held busy", upd_busy, 0);
    chk("R9 held window", cnt_wr_en, 0);
    div_hold = 0;

    // R9 abort in lead
    push(E_RISE, 0, 0);
    push(E_FALL, -1, 0);
    pulse_sec();
    repeat (3) @(negedge clk);
    div_hold = 1;
    repeat (2) @(negedge clk);
    chk("R9 abort busy", upd_busy, 0);
    chk("R9 abort no done", upd_done, 0);
    div_hold = 0;
    repeat (40) @(negedge clk);
    chk("R9 no late window", cnt_wr_en, 0);

    // R8 inhibit during a fresh cycle
    upd_irq_inh = 1;
    run_cycle();
    chk("R6 done again", upd_done, 1);
    chk("R8 inhibited irq", irq_upd, 0);
    upd_irq_inh = 0; @(negedge clk);
    chk("R8 released irq", irq_upd, 1);

    repeat (5) @(negedge clk);
    chk("R2 queue empty", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule